// File: doc/BRIEF.md
# Interrupt Acceptance and Restart Vector Controller

This block decides, once per clock, whether a pending interrupt is accepted and which 16-bit restart address goes with it. Five sources compete. One is a non-maskable line. Three are maskable lines with fixed vectors placed halfway between two eight-byte restart slots. The last is an externally vectored request that carries a 3-bit restart number. The block holds the global interrupt enable, a 3-bit mask for the fixed-vector lines, a rising-edge latch for the non-maskable line and another for the highest fixed-vector line, and a halt state.

When a source is accepted, a small state machine runs a fixed handshake. First it raises an acknowledge pulse carrying the vector. Next it asks the core to push the return address. Last it asks for the jump to the vector. Entry to an interrupt therefore looks like a one-byte subroutine call. The core does the stack write and the fetch itself.

States: `ST_RUN` (normal execution), `ST_HALT` (halted), `ST_ACK` (acknowledge), `ST_PUSH` (return-address push request) and `ST_JUMP` (jump request). Transitions: RUN to HALT on a halt command with nothing accepted; RUN or HALT to ACK when a source is accepted; ACK to PUSH, PUSH to JUMP and JUMP to RUN unconditionally; HALT holds until an accepted source or reset.

Top module: `irq_restart_ctl`

## Requirements
- R1: After reset, int_en is 0, halted, int_ack, push_req and jump_req are 0, ack_vec is 0, and all three line masks are set, so no maskable fixed-vector line is accepted until the mask is rewritten.
- R2: An accepted external request with restart number n (0..7) gives ack_vec = n*8 (0000h to 0038h).
- R3: The fixed vectors are 0024h for the non-maskable line, 002Ch for lvl_lo_in, 0034h for lvl_mid_in and 003Ch for edge_hi_in.
- R4: When several sources are eligible in the same cycle, the order is non-maskable, then edge_hi_in, lvl_mid_in, lvl_lo_in, and the external request last.
- R5: cmd_en sets int_en and cmd_dis clears it, and cmd_dis wins when both are given together. While int_en is 0, only the non-maskable line is accepted.
- R6: Accepting any source clears int_en, so int_en is 0 in the acknowledge cycle.
- R7: An acceptance gives int_ack for one cycle, then push_req for one cycle, then jump_req for one cycle, with ack_vec held through all three. Sources are accepted only in the run or halt state, and ack_vec is 0 outside the sequence.
- R8: cmd_setmask loads mask_data, where bit 0 masks lvl_lo_in, bit 1 masks lvl_mid_in and bit 2 masks edge_hi_in (1 = masked). A masked line is not accepted and does not block a lower-priority line.
- R9: A rising edge on edge_hi_in is latched whatever the mask and enable. The latch stays pending until that line is accepted or until cmd_setmask is given with mask_clr_hi = 1. lvl_lo_in and lvl_mid_in are not latched.
- R10: cmd_halt in the run state, with nothing accepted in that cycle, enters the halt state (halted = 1). The halt state is left only through an accepted source, or by reset. cmd_halt in any other state has no effect.
- R11: The non-maskable line is accepted once per rising edge. Holding it high does not cause a second acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| lvl_lo_in | input | 1 | Maskable level request, vector 002Ch |
| lvl_mid_in | input | 1 | Maskable level request, vector 0034h |
| edge_hi_in | input | 1 | Maskable edge request, vector 003Ch |
| ext_req | input | 1 | Externally vectored level request |
| ext_num | input | 3 | Restart number for ext_req |
| cmd_en | input | 1 | Set global enable |
| cmd_dis | input | 1 | Clear global enable |
| cmd_setmask | input | 1 | Load line masks |
| mask_data | input | 3 | New mask bits (bit0 lo, bit1 mid, bit2 hi) |
| mask_clr_hi | input | 1 | With cmd_setmask, drop a latched edge_hi_in request |
| cmd_halt | input | 1 | Enter the halt state |
| int_en | output | 1 | Global enable flip-flop |
| int_ack | output | 1 | Acknowledge pulse |
| push_req | output | 1 | Request to push the return address |
| jump_req | output | 1 | Request to jump to ack_vec |
| halted | output | 1 | Halt state indicator |
| ack_vec | output | 16 | Restart address during the entry sequence |

## Verification
A level source (lvl_lo_in, lvl_mid_in, ext_req) that is present before a clock edge gives int_ack just after that edge. An edge source (nmi_in, edge_hi_in) first sets its latch on one edge and gives int_ack after the next. A command changes int_en or the mask at the edge that samples it, so any acceptance that depends on the new value comes one edge later. push_req and jump_req follow int_ack by one and two cycles. The bench drives inputs on the falling edge and compares on the next falling edge. Directed checks wait exactly these edge counts, and the random phase compares every cycle against a cycle model that advances on the same rising edge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int ADDR_W     = 16;
    localparam int RST_W      = 3;
    localparam int SLOT_SHIFT = 3;
    localparam int N_MASK     = 3;
    localparam int HALF_OFS   = 1 << (SLOT_SHIFT - 1);

    localparam logic [RST_W-1:0] SLOT_NMI = RST_W'(4);
    localparam logic [RST_W-1:0] SLOT_LO  = RST_W'(5);
    localparam logic [RST_W-1:0] SLOT_MID = RST_W'(6);
    localparam logic [RST_W-1:0] SLOT_HI  = RST_W'(7);

    typedef enum logic [2:0] {
        ST_RUN, ST_HALT, ST_ACK, ST_PUSH, ST_JUMP
    } ctl_state_t;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_NMI, SRC_HI, SRC_MID, SRC_LO, SRC_EXT
    } irq_src_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [RST_W-1:0] slot,
                                                    input logic half);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(slot) << SLOT_SHIFT;
        if (half) a = a | ADDR_W'(HALF_OFS);
        return a;
    endfunction

endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = din & ~prev_q;
    assign pend = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= din;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
(
    input  logic              allow,
    input  logic              en,
    input  logic [N_MASK-1:0] mask,
    input  logic              nmi_p,
    input  logic              hi_p,
    input  logic              mid_lvl,
    input  logic              lo_lvl,
    input  logic              ext_req,
    input  logic [RST_W-1:0]  ext_num,
    output logic              take,
    output irq_src_t          src,
    output logic [ADDR_W-1:0] vec
);
    always_comb begin
        src = SRC_NONE;
        vec = '0;
        if (allow) begin
            if (nmi_p) begin
                src = SRC_NMI;
                vec = slot_addr(SLOT_NMI, 1'b1);
            end else if (en && hi_p && !mask[2]) begin
                src = SRC_HI;
                vec = slot_addr(SLOT_HI, 1'b1);
            end else if (en && mid_lvl && !mask[1]) begin
                src = SRC_MID;
                vec = slot_addr(SLOT_MID, 1'b1);
            end else if (en && lo_lvl && !mask[0]) begin
                src = SRC_LO;
                vec = slot_addr(SLOT_LO, 1'b1);
            end else if (en && ext_req) begin
                src = SRC_EXT;
                vec = slot_addr(ext_num, 1'b0);
            end
        end
        take = (src != SRC_NONE);
    end
endmodule

// File: rtl/irq_restart_ctl.sv
module irq_restart_ctl
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              lvl_lo_in,
    input  logic              lvl_mid_in,
    input  logic              edge_hi_in,
    input  logic              ext_req,
    input  logic [RST_W-1:0]  ext_num,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_setmask,
    input  logic [N_MASK-1:0] mask_data,
    input  logic              mask_clr_hi,
    input  logic              cmd_halt,
    output logic              int_en,
    output logic              int_ack,
    output logic              push_req,
    output logic              jump_req,
    output logic              halted,
    output logic [ADDR_W-1:0] ack_vec
);
    localparam int N_EDGE = 2;

    ctl_state_t        state_q, state_d;
    logic              ie_q;
    logic [N_MASK-1:0] mask_q;
    logic [ADDR_W-1:0] vec_q;

    logic              allow, take;
    irq_src_t          src;
    logic [ADDR_W-1:0] vec_nx;

    logic [N_EDGE-1:0] edge_raw, edge_clr, edge_pend;

    assign edge_raw = {edge_hi_in, nmi_in};
    assign edge_clr[0] = take && (src == SRC_NMI);
    assign edge_clr[1] = (take && (src == SRC_HI)) || (cmd_setmask && mask_clr_hi);

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        irq_edge_catch u_catch (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (edge_raw[g]),
            .clr  (edge_clr[g]),
            .pend (edge_pend[g])
        );
    end

    assign allow = (state_q == ST_RUN) || (state_q == ST_HALT);

    irq_prio_pick u_pick (
        .allow  (allow),
        .en     (ie_q),
        .mask   (mask_q),
        .nmi_p  (edge_pend[0]),
        .hi_p   (edge_pend[1]),
        .mid_lvl(lvl_mid_in),
        .lo_lvl (lvl_lo_in),
        .ext_req(ext_req),
        .ext_num(ext_num),
        .take   (take),
        .src    (src),
        .vec    (vec_nx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (take) state_d = ST_ACK;
                     else if (cmd_halt) state_d = ST_HALT;
            ST_HALT: if (take) state_d = ST_ACK;
            ST_ACK:  state_d = ST_PUSH;
            ST_PUSH: state_d = ST_JUMP;
            ST_JUMP: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // enable, mask and vector registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
            vec_q  <= '0;
        end else begin
            if (take)         ie_q <= 1'b0;
            else if (cmd_dis) ie_q <= 1'b0;
            else if (cmd_en)  ie_q <= 1'b1;
            if (cmd_setmask) mask_q <= mask_data;
            if (take)        vec_q  <= vec_nx;
        end
    end

    // outputs
    always_comb begin
        int_ack  = 1'b0;
        push_req = 1'b0;
        jump_req = 1'b0;
        halted   = 1'b0;
        ack_vec  = '0;
        unique case (state_q)
            ST_RUN:  ;
            ST_HALT: halted = 1'b1;
            ST_ACK:  begin int_ack  = 1'b1; ack_vec = vec_q; end
            ST_PUSH: begin push_req = 1'b1; ack_vec = vec_q; end
            ST_JUMP: begin jump_req = 1'b1; ack_vec = vec_q; end
            default: ;
        endcase
        int_en = ie_q;
    end
endmodule

// File: rtl/irq_restart_chk.sv
module irq_restart_chk
    import irq_vec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              int_en,
    input logic              int_ack,
    input logic              push_req,
    input logic              jump_req,
    input logic              halted,
    input logic [ADDR_W-1:0] ack_vec
);
    // R7
    ack_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> push_req);
    // R7
    push_then_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> jump_req);
    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req || jump_req) |-> $stable(ack_vec));
    // R7
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_ack, push_req, jump_req, halted}));
    // R6
    ack_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> !int_en);
    // R10
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> int_ack);
    // R2
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ((ack_vec[2:0] == 3'd0 || ack_vec[2:0] == 3'd4) && ack_vec < 16'h0040));
endmodule

bind irq_restart_ctl irq_restart_chk u_chk (.*);

// File: tb/test_irq_restart_ctl.sv
`timescale 1ns/1ps
module test_irq_restart_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_in = 0, lvl_lo_in = 0, lvl_mid_in = 0, edge_hi_in = 0, ext_req = 0;
    logic [2:0] ext_num = 0;
    logic cmd_en = 0, cmd_dis = 0, cmd_setmask = 0, mask_clr_hi = 0, cmd_halt = 0;
    logic [2:0] mask_data = 0;
    logic int_en, int_ack, push_req, jump_req, halted;
    logic [15:0] ack_vec;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_restart_ctl i_irq_restart_ctl (.*);

    // ---------------- cycle model built from the requirements ----------------
    int          m_st;      // 0 run, 1 halt, 2 ack, 3 push, 4 jump
    logic        m_ie, m_pn, m_ph, m_prn, m_prh;
    logic [2:0]  m_mask;
    logic [15:0] m_vec;
    int          t_src;
    logic [15:0] t_v;
    logic        t_rn, t_rh;

    function automatic logic [15:0] exp_vec(input int s, input logic [2:0] n);
        case (s)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return {10'd0, n, 3'd0};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ie = 0; m_mask = 3'b111; m_vec = 0;
            m_pn = 0; m_ph = 0; m_prn = 0; m_prh = 0;
        end else begin
            t_rn = nmi_in & ~m_prn;
            t_rh = edge_hi_in & ~m_prh;
            t_src = 0;
            if (m_st <= 1) begin
                if (m_pn) t_src = 1;
                else if (m_ie && m_ph && !m_mask[2]) t_src = 2;
                else if (m_ie && lvl_mid_in && !m_mask[1]) t_src = 3;
                else if (m_ie && lvl_lo_in && !m_mask[0]) t_src = 4;
                else if (m_ie && ext_req) t_src = 5;
            end
            t_v = exp_vec(t_src, ext_num);
            if (t_src != 0) begin m_vec = t_v; m_ie = 0; end
            else if (cmd_dis) m_ie = 0;
            else if (cmd_en) m_ie = 1;
            m_pn = (m_pn & ~(t_src == 1)) | t_rn;
            m_ph = (m_ph & ~(t_src == 2) & ~(cmd_setmask & mask_clr_hi)) | t_rh;
            if (cmd_setmask) m_mask = mask_data;
            m_prn = nmi_in;
            m_prh = edge_hi_in;
            if (t_src != 0) m_st = 2;
            else case (m_st)
                0: m_st = cmd_halt ? 1 : 0;
                1: m_st = 1;
                2: m_st = 3;
                3: m_st = 4;
                default: m_st = 0;
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic en_cmd();
        cmd_en = 1; tick(); cmd_en = 0;
    endtask

    task automatic smask(input logic [2:0] m, input logic c);
        cmd_setmask = 1; mask_data = m; mask_clr_hi = c;
        tick();
        cmd_setmask = 0; mask_clr_hi = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        ticks(3);
        rst_n = 1;
        tick();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 int_en", int_en, 0);
        chk("R1 phase", {int_ack, push_req, jump_req, halted}, 0);
        chk("R1 vec", ack_vec, 0);
        en_cmd();
        lvl_lo_in = 1; tick();
        chk("R1 masks set at reset", int_ack, 0);
        lvl_lo_in = 0;
        cmd_dis = 1; tick(); cmd_dis = 0;

        // R2 external restart numbers
        for (int n = 0; n < 8; n++) begin
            en_cmd();
            ext_req = 1; ext_num = 3'(n);
            tick();
            chk("R2 ack", int_ack, 1);
            chk("R2 vec", ack_vec, 32'(n * 8));
            chk("R6 en cleared", int_en, 0);
            ext_req = 0;
            tick(); chk("R7 push", {int_ack, push_req, jump_req}, 3'b010);
            chk("R7 vec held push", ack_vec, 32'(n * 8));
            tick(); chk("R7 jump", {int_ack, push_req, jump_req}, 3'b001);
            chk("R7 vec held jump", ack_vec, 32'(n * 8));
            tick(); chk("R7 back to run", {int_ack, push_req, jump_req, halted}, 0);
            chk("R7 vec idle", ack_vec, 0);
        end

        // R3 fixed vectors
        smask(3'b000, 0);
        en_cmd(); lvl_lo_in = 1; tick();
        chk("R3 lo vec", ack_vec, 16'h002C); lvl_lo_in = 0; ticks(3);
        en_cmd(); lvl_mid_in = 1; tick();
        chk("R3 mid vec", ack_vec, 16'h0034); lvl_mid_in = 0; ticks(3);
        en_cmd(); edge_hi_in = 1; tick();
        chk("R9 hi latch delay", int_ack, 0);
        tick();
        chk("R3 hi vec", ack_vec, 16'h003C); edge_hi_in = 0; ticks(3);
        nmi_in = 1; ticks(2);
        chk("R5 nmi while disabled", int_ack, 1);
        chk("R3 nmi vec", ack_vec, 16'h0024); nmi_in = 0; ticks(3);

        // R4 priority
        en_cmd(); lvl_lo_in = 1; lvl_mid_in = 1; ext_req = 1; ext_num = 3'd1; tick();
        chk("R4 mid over lo/ext", ack_vec, 16'h0034); lvl_mid_in = 0; ticks(3);
        en_cmd(); tick();
        chk("R4 lo over ext", ack_vec, 16'h002C); lvl_lo_in = 0; ticks(3);
        en_cmd(); tick();
        chk("R4 ext last", ack_vec, 16'h0008); ext_req = 0; ticks(3);
        en_cmd(); nmi_in = 1; edge_hi_in = 1; ticks(2);
        chk("R4 nmi over hi", ack_vec, 16'h0024); nmi_in = 0; edge_hi_in = 0; ticks(3);
        en_cmd(); tick();
        chk("R9 hi stays pending", ack_vec, 16'h003C); ticks(3);

        // R8 masks
        smask(3'b010, 0);
        en_cmd(); lvl_mid_in = 1; tick();
        chk("R8 mid masked", int_ack, 0); tick();
        chk("R8 mid masked 2", int_ack, 0);
        lvl_lo_in = 1; tick();
        chk("R8 lower line passes", ack_vec, 16'h002C);
        lvl_lo_in = 0; lvl_mid_in = 0; ticks(3);
        smask(3'b100, 0);
        en_cmd(); edge_hi_in = 1; tick(); edge_hi_in = 0; tick();
        chk("R8 hi masked", int_ack, 0); tick();
        chk("R8 hi masked 2", int_ack, 0);
        smask(3'b000, 0); tick();
        chk("R8 hi after unmask", ack_vec, 16'h003C); ticks(3);

        // R9 clear through set-mask, and level lines not latched
        edge_hi_in = 1; tick(); edge_hi_in = 0; tick();
        smask(3'b000, 1);
        en_cmd(); tick();
        chk("R9 hi cleared", int_ack, 0); tick();
        chk("R9 hi cleared 2", int_ack, 0);
        cmd_dis = 1; tick(); cmd_dis = 0;
        lvl_lo_in = 1; tick(); lvl_lo_in = 0;
        en_cmd(); tick();
        chk("R9 level not latched", int_ack, 0);

        // R5 enable/disable
        chk("R5 enabled", int_en, 1);
        cmd_dis = 1; tick(); cmd_dis = 0;
        chk("R5 disabled", int_en, 0);
        lvl_lo_in = 1; tick();
        chk("R5 blocked when disabled", int_ack, 0); lvl_lo_in = 0;
        cmd_en = 1; cmd_dis = 1; tick(); cmd_en = 0; cmd_dis = 0;
        chk("R5 dis wins", int_en, 0);

        // R10 halt
        cmd_halt = 1; tick(); cmd_halt = 0;
        chk("R10 halted", halted, 1);
        lvl_lo_in = 1; ticks(2);
        chk("R10 no wake while disabled", {halted, int_ack}, 2'b10);
        en_cmd();
        chk("R10 still halted", {halted, int_en}, 2'b11);
        tick();
        chk("R10 wake on accept", {halted, int_ack}, 2'b01);
        lvl_lo_in = 0; ticks(3);
        chk("R10 runs after entry", halted, 0);
        cmd_halt = 1; tick(); cmd_halt = 0; nmi_in = 1; ticks(2);
        chk("R10 nmi wakes halt", {halted, int_ack}, 2'b01); ticks(3);

        // R11 nmi held high gives one acceptance
        ticks(3);
        chk("R11 no second nmi", int_ack, 0);
        nmi_in = 0; tick();

        // random phase against the cycle model
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            nmi_in      = ($urandom % 20) == 0;
            lvl_lo_in   = ($urandom % 4) == 0;
            lvl_mid_in  = ($urandom % 5) == 0;
            edge_hi_in  = ($urandom % 6) == 0;
            ext_req     = ($urandom % 3) == 0;
            ext_num     = 3'($urandom);
            cmd_en      = ($urandom % 4) == 0;
            cmd_dis     = ($urandom % 9) == 0;
            cmd_setmask = ($urandom % 12) == 0;
            mask_data   = 3'($urandom);
            mask_clr_hi = ($urandom % 2) == 0;
            cmd_halt    = ($urandom % 15) == 0;
            tick();
            chk("R4 R5 R6 R7 R8 R9 R10 R11 random outputs",
                {int_en, int_ack, push_req, jump_req, halted, ack_vec},
                {m_ie, m_st == 2, m_st == 3, m_st == 4, m_st == 1,
                 (m_st >= 2) ? m_vec : 16'h0000});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule